// File: doc/BRIEF.md
# SCL Bit-Rate Generator

This block times the serial clock of a two-wire bus master. A reference clock is divided by a selectable power of two to form a count clock. Each SCL half-period, low and high, is timed from its own 5-bit count. The low phase is driven actively. The high phase is released, and its timing only begins once the line is seen high. A slave that holds the line low therefore stretches the clock. Two single-cycle ticks tell a byte engine when each phase ends.

Every phase lasts longer than its programmed count. A fixed overhead for input synchronisation and glitch filtering is added to it, and that overhead is one cycle larger when the divider is bypassed. The divider select sits behind an unlock qualifier, so a careless write cannot retime the bus. The reserved upper bits of the count registers are not brought into the block.

There is no data stream here. All pins are plain control and status levels, with no handshake and no back-pressure.

Top module: `scl_rate_gen`

## Requirements
- R1: While rst_n is low, scl_drive_low, tick_low_end and tick_high_end are 0, and the divider select returns to 0.
- R2: When gen_en is low, SCL is released from the next clock on, and the divider and phase counters are held at zero. After gen_en rises again, the block starts with a low phase of full length.
- R3: With a select value s from 0 to 6, the count clock runs at the reference rate divided by 2^s. A select of 7 behaves as 6.
- R4: A pulse on mode_wr loads mode_sel into the divider select only when mode_unlock is 1 in that cycle. Otherwise the select keeps its value.
- R5: A count value of 0 is treated as 1, the minimum count.
- R6: A phase lasts (count + 4) count-clock cycles when the effective select is 0, and (count + 3) count-clock cycles otherwise. In steady operation a low phase therefore spans that number times 2^s reference cycles.
- R7: The high phase starts counting only once the filtered SCL input is high. While the line is held low externally, the block neither drives SCL nor ends the high phase.
- R8: scl_in passes through a two-flop synchroniser and then a filter. The filter changes its output only when two successive synchronised samples agree, so a pulse one reference cycle wide has no effect.
- R9: tick_low_end is high during the last reference cycle of each low phase, and tick_high_end during the last reference cycle of each high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_en | input | 1 | Generator enable; low releases SCL and clears the counters |
| mode_wr | input | 1 | Write strobe for the divider select |
| mode_unlock | input | 1 | Qualifier that must be 1 for a select write to take effect |
| mode_sel | input | 3 | New divider select (exponent of two) |
| low_count | input | 5 | Low-phase count |
| high_count | input | 5 | High-phase count |
| scl_in | input | 1 | SCL line level fed back from the pad |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| tick_low_end | output | 1 | Last reference cycle of a low phase |
| tick_high_end | output | 1 | Last reference cycle of a high phase |

## Verification
The bench measures steady-state low phases for the bypassed divider, a divide-by-four select, a select of 7 and a zero count. A design with the wrong overhead, no clamp or no minimum count gives lengths that are off by a whole count-clock multiple. It issues a select write without the unlock qualifier; a design that ignored the qualifier would change the measured low length. It holds SCL low across a high phase, then repeats that with a one-cycle glitch in the hold. A design that counted without seeing the line high, or did not filter glitches, would end the high phase and drive low during the hold. It disables the block in mid-phase and checks that SCL is released at once and that the first low phase afterwards is full length, which catches stale counters.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;

  // count-clock cycles of sync/filter overhead added to every phase
  localparam int OVH_BYPASS = 4;
  localparam int OVH_DIV    = 3;
endpackage

// File: rtl/scl_clk_sel.sv
module scl_clk_sel #(
  parameter int SEL_W   = 3,
  parameter int MAX_SEL = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             mode_wr,
  input  logic             mode_unlock,
  input  logic [SEL_W-1:0] mode_sel,
  output logic             cc_tick,
  output logic             bypass
);
  localparam int PRE_W = (MAX_SEL > 0) ? MAX_SEL : 1;

  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_eff;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sel_q <= '0;
    else if (mode_wr && mode_unlock)
      sel_q <= mode_sel;
  end

  always_comb begin
    sel_eff = (sel_q > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : sel_q;
    lim     = PRE_W'((32'd1 << sel_eff) - 32'd1);
    cc_tick = en && (pre_q >= lim);
    bypass  = (sel_eff == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pre_q <= '0;
    else if (!en)
      pre_q <= '0;
    else if (cc_tick)
      pre_q <= '0;
    else
      pre_q <= pre_q + PRE_W'(1);
  end

  AST_PRE_HELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pre_q == '0)); // R2
  AST_DIV_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && cc_tick && !bypass) |-> !$past(cc_tick)); // R3
  AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_wr && mode_unlock) |=> $stable(sel_q)); // R4
endmodule

// File: rtl/scl_in_filter.sv
module scl_in_filter #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  output logic scl_filt
);
  logic [STAGES-1:0] chain_q;
  logic              synced;
  logic              last_q;
  logic              filt_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        chain_q[g] <= 1'b1;
      else if (g == 0)
        chain_q[g] <= scl_raw;
      else
        chain_q[g] <= chain_q[(g > 0) ? g - 1 : 0];
    end
  end

  assign synced = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b1;
      filt_q <= 1'b1;
    end else begin
      last_q <= synced;
      if (synced == last_q)
        filt_q <= synced;
    end
  end

  assign scl_filt = filt_q;

  AST_FILT_RISE_AGREED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt_q) |-> ($past(synced, 1) && $past(synced, 2))); // R8
  AST_FILT_FALL_AGREED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(filt_q) |-> (!$past(synced, 1) && !$past(synced, 2))); // R8
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cc_tick,
  input  logic             bypass,
  input  logic [CNT_W-1:0] low_field,
  input  logic [CNT_W-1:0] high_field,
  input  logic             scl_filt,
  output logic             drive_low,
  output logic             low_end,
  output logic             high_end
);
  localparam int LEN_W = CNT_W + 1;

  phase_e           st_q;
  logic [LEN_W-1:0] cnt_q;
  logic [CNT_W-1:0] field [2];
  logic [LEN_W-1:0] plen  [2];
  logic [LEN_W-1:0] cur_len;
  logic             last;

  assign field[0] = low_field;
  assign field[1] = high_field;

  for (genvar p = 0; p < 2; p++) begin : g_len
    always_comb begin
      plen[p] = LEN_W'((field[p] == '0) ? CNT_W'(1) : field[p])
              + (bypass ? LEN_W'(OVH_BYPASS) : LEN_W'(OVH_DIV));
    end
  end

  always_comb begin
    cur_len   = (st_q == PH_LOW) ? plen[0] : plen[1];
    last      = (cnt_q == cur_len - LEN_W'(1));
    drive_low = (st_q == PH_LOW);
    low_end   = (st_q == PH_LOW)  && cc_tick && last;
    high_end  = (st_q == PH_HIGH) && cc_tick && last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (!en) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        PH_IDLE: begin
          st_q  <= PH_LOW;
          cnt_q <= '0;
        end
        PH_LOW: if (cc_tick) begin
          if (last) begin
            st_q  <= PH_WAIT;
            cnt_q <= '0;
          end else
            cnt_q <= cnt_q + LEN_W'(1);
        end
        PH_WAIT: if (scl_filt) begin
          st_q  <= PH_HIGH;
          cnt_q <= '0;
        end
        PH_HIGH: if (cc_tick) begin
          if (last) begin
            st_q  <= PH_LOW;
            cnt_q <= '0;
          end else
            cnt_q <= cnt_q + LEN_W'(1);
        end
        default: st_q <= PH_IDLE;
      endcase
    end
  end

  AST_RELEASE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !drive_low); // R2
  AST_HIGH_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == PH_HIGH) |-> $past(scl_filt)); // R7
  AST_LOW_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(drive_low) && $past(low_end)) |->
      ($past(drive_low, 2) && $past(drive_low, 3) && $past(drive_low, 4))); // R6
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int SEL_W       = 3,
  parameter int MAX_SEL     = 6,
  parameter int CNT_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic             mode_wr,
  input  logic             mode_unlock,
  input  logic [SEL_W-1:0] mode_sel,
  input  logic [CNT_W-1:0] low_count,
  input  logic [CNT_W-1:0] high_count,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             tick_low_end,
  output logic             tick_high_end
);
  logic cc_tick;
  logic bypass;
  logic scl_filt;

  scl_clk_sel #(.SEL_W(SEL_W), .MAX_SEL(MAX_SEL)) u_clk_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (gen_en),
    .mode_wr     (mode_wr),
    .mode_unlock (mode_unlock),
    .mode_sel    (mode_sel),
    .cc_tick     (cc_tick),
    .bypass      (bypass)
  );

  scl_in_filter #(.STAGES(SYNC_STAGES)) u_in_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_raw  (scl_in),
    .scl_filt (scl_filt)
  );

  scl_phase_timer #(.CNT_W(CNT_W)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (gen_en),
    .cc_tick    (cc_tick),
    .bypass     (bypass),
    .low_field  (low_count),
    .high_field (high_count),
    .scl_filt   (scl_filt),
    .drive_low  (scl_drive_low),
    .low_end    (tick_low_end),
    .high_end   (tick_high_end)
  );

  AST_NO_TICK_RESET: assert property (@(posedge clk)
    !rst_n |-> (!scl_drive_low && !tick_low_end && !tick_high_end)); // R1
endmodule

// File: tb/test_scl_rate_gen.sv
module test_scl_rate_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gen_en = 1'b0;
  logic       mode_wr = 1'b0;
  logic       mode_unlock = 1'b0;
  logic [2:0] mode_sel = 3'd0;
  logic [4:0] low_count = 5'd5;
  logic [4:0] high_count = 5'd3;
  logic       slave_hold = 1'b0;
  logic       glitch = 1'b0;
  logic       scl_bus;
  logic       scl_drive_low, tick_low_end, tick_high_end;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit cmp_on = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  assign scl_bus = glitch ? 1'b1 : !(scl_drive_low || slave_hold);

  scl_rate_gen i_scl_rate_gen (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en),
    .mode_wr(mode_wr), .mode_unlock(mode_unlock), .mode_sel(mode_sel),
    .low_count(low_count), .high_count(high_count), .scl_in(scl_bus),
    .scl_drive_low(scl_drive_low), .tick_low_end(tick_low_end),
    .tick_high_end(tick_high_end)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference: 0 idle, 1 low, 2 waiting for line, 3 high
  int m_sel = 0, m_pre = 0, m_st = 0, m_e = 0;
  bit m_f = 1'b1;
  bit hist[$] = '{1'b1, 1'b1, 1'b1};

  function automatic int eff_sel();
    return (m_sel > 6) ? 6 : m_sel;
  endfunction
  function automatic bit m_cc();
    return gen_en && (m_pre >= (1 << eff_sel()) - 1);
  endfunction
  function automatic int plen(int field);
    return ((field == 0) ? 1 : field) + ((eff_sel() == 0) ? 4 : 3);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst_n) begin
      bit cc, fn;
      int ll, lh;
      cc = m_cc();
      ll = plen(int'(low_count));
      lh = plen(int'(high_count));
      fn = (hist[1] == hist[2]) ? hist[1] : m_f;
      if (!gen_en) begin
        m_pre = 0; m_st = 0; m_e = 0;
      end else begin
        m_pre = cc ? 0 : m_pre + 1;
        case (m_st)
          0: begin m_st = 1; m_e = 0; end
          1: if (cc) begin
               if (m_e == ll - 1) begin m_st = 2; m_e = 0; end
               else m_e++;
             end
          2: if (m_f) begin m_st = 3; m_e = 0; end
          default: if (cc) begin
               if (m_e == lh - 1) begin m_st = 1; m_e = 0; end
               else m_e++;
             end
        endcase
      end
      hist.push_front(scl_bus);
      void'(hist.pop_back());
      m_f = fn;
      if (mode_wr && mode_unlock) m_sel = int'(mode_sel);
    end
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // per-cycle comparison against the reference, and low-phase length log
  int lens[$];
  int run = 0;
  always @(negedge clk) begin
    if (cmp_on) begin
      bit cc;
      cc = m_cc();
      chk("R6 drive_low vs model", int'(scl_drive_low), int'(m_st == 1));
      chk("R9 tick_low_end vs model", int'(tick_low_end),
          int'(m_st == 1 && cc && m_e == plen(int'(low_count)) - 1));
      chk("R9 tick_high_end vs model", int'(tick_high_end),
          int'(m_st == 3 && cc && m_e == plen(int'(high_count)) - 1));
    end
    if (scl_drive_low) run++;
    else if (run > 0) begin lens.push_back(run); run = 0; end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #5; end
  endtask

  task automatic setup(bit unlock, int sel, int lo, int hi);
    gen_en = 1'b0;
    step(3);
    mode_wr = 1'b1; mode_unlock = unlock; mode_sel = 3'(sel);
    step();
    mode_wr = 1'b0; mode_unlock = 1'b0;
    low_count = 5'(lo); high_count = 5'(hi);
    step();
    lens.delete();
    gen_en = 1'b1;
  endtask

  function automatic int second_len();
    return (lens.size() > 1) ? lens[1] : -1;
  endfunction

  task automatic wait_fall();
    bit prev;
    prev = scl_drive_low;
    for (int i = 0; i < 400; i++) begin
      step();
      if (prev && !scl_drive_low) break;
      prev = scl_drive_low;
    end
  endtask

  task automatic hold_test(bit with_glitch, string req);
    int ends = 0, drives = 0, seen = 0;
    setup(1'b1, 0, 5, 3);
    step(40);
    wait_fall();
    slave_hold = 1'b1;
    for (int i = 0; i < 40; i++) begin
      if (with_glitch && i == 10) glitch = 1'b1;
      step();
      glitch = 1'b0;
      ends += int'(tick_high_end);
      drives += int'(scl_drive_low);
    end
    chk({req, " no high end while held"}, ends, 0);
    chk({req, " no drive while held"}, drives, 0);
    slave_hold = 1'b0;
    for (int i = 0; i < 40; i++) begin
      step();
      if (scl_drive_low) seen = 1;
    end
    chk({req, " resumes after release"}, seen, 1);
  endtask

  initial begin
    step(3);
    // R1: reset values
    chk("R1 drive in reset", int'(scl_drive_low), 0);
    chk("R1 ticks in reset", int'(tick_low_end | tick_high_end), 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    step(3);
    chk("R1 released while disabled", int'(scl_drive_low), 0);

    // R6: bypassed divider, count 5 -> 9 cycles
    setup(1'b1, 0, 5, 3);
    step(100);
    chk("R6 low len sel0", second_len(), 9);

    // R5: count 0 behaves as 1 -> 5 cycles
    setup(1'b1, 0, 0, 0);
    step(100);
    chk("R5 low len zero count", second_len(), 5);

    // R3 R6: divide by 4, count 5 -> (5+3)*4
    setup(1'b1, 2, 5, 3);
    step(300);
    chk("R3 low len sel2", second_len(), 32);

    // R4: locked write must not change the select
    setup(1'b0, 5, 5, 3);
    step(300);
    chk("R4 locked select write", second_len(), 32);

    // R3: select 7 behaves as 6 -> (1+3)*64
    setup(1'b1, 7, 1, 1);
    step(1300);
    chk("R3 clamp select 7", second_len(), 256);

    // R2: disable mid-run, then restart
    setup(1'b1, 0, 5, 3);
    step(30);
    while (!scl_drive_low) step();
    gen_en = 1'b0;
    step();
    begin
      int d = 0;
      for (int i = 0; i < 5; i++) begin d += int'(scl_drive_low); step(); end
      chk("R2 released when disabled", d, 0);
    end
    lens.delete();
    gen_en = 1'b1;
    step(60);
    chk("R2 first low after restart", (lens.size() > 0) ? lens[0] : -1, 9);

    // R7: slave stretches the high phase
    hold_test(1'b0, "R7");
    // R8: single-cycle glitch during the hold is ignored
    hold_test(1'b1, "R8");

    gen_en = 1'b0;
    step(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule